// File: doc/BRIEF.md
# Accumulator ALU with flag update

A purely combinational arithmetic and logic unit for an 8-bit microcontroller datapath built around a 16-bit accumulator and a 16-bit temporary register. Each cycle the core's decoder presents a decoded operation code, the current accumulator, the temporary register, one byte operand (a register, immediate or memory value already fetched), the current condition flags and the half carry left by the previous add or subtract. The unit returns the result word, three write enables (accumulator low byte, accumulator high byte, general register) and the new flag vector. Every operation has its own flag rule: some flags are computed and the rest pass through untouched.

Operations covered are add and subtract with carry in byte and word forms, byte and word compare, register and accumulator increment and decrement, byte and word AND/OR/XOR, rotate through carry, and decimal adjust after addition or subtraction. Register-to-register subtract and compare take the temporary register as the minuend. Decimal adjust is a generate-time option (`DECIMAL_EN`); when left out, its codes behave as no-operations.

Top module: `acc_alu`

## Requirements
- R1: Flags are packed as flags[3]=N, flags[2]=Z, flags[1]=V, flags[0]=C. Byte add with carry computes AL+opnd+C (code ADDC_OP) or AL+TL+C (code ADDC_T) over 8 bits; the result goes to AL only (wr_lo_o=1, wr_hi_o=0, res_o[15:8]=AH) and N, Z, V, C all update, N being bit 7 and Z meaning the byte is zero.
- R2: Word add with carry (ADDCW) computes A+T+C over 16 bits, asserts both accumulator write enables, takes N from bit 15 and Z from all 16 bits, and updates V and C.
- R3: Subtract with borrow computes AL-opnd-C (SUBC_OP), TL-AL-C (SUBC_T) or T-A-C (SUBCW, word); C is set when a borrow occurs and V is signed overflow; byte forms write AL only, the word form writes both bytes.
- R4: Compare forms compute AL-opnd (CMP_OP), TL-AL (CMP_T) or T-A (CMPW) ignoring the incoming carry, assert no write enable and update N, Z, V, C.
- R5: Register increment and decrement (INC_R, DEC_R) return opnd+1 or opnd-1 in res_o[7:0] with res_o[15:8]=0, assert only wr_reg_o, update N, Z, V and leave C unchanged.
- R6: Accumulator word increment and decrement (INCW_A, DECW_A) return A+1 or A-1 over 16 bits, write both bytes, update N and Z and leave V and C unchanged.
- R7: Logic forms (AND_OP, OR_OP, XOR_OP with the operand; AND_T, XOR_T with TL; ANDW, ORW, XORW of A with T) set N and Z from the result width, clear V and leave C unchanged; byte forms write AL only.
- R8: RORC shifts AL right with C entering bit 7 and bit 0 leaving into C; ROLC shifts AL left with C entering bit 0 and bit 7 leaving into C; N and Z follow the new AL and V is unchanged.
- R9: DAA and DAS add or subtract 0x06 when AL[3:0]>9 or hc_i is set, and 0x60 when AL>0x99 or C is set; C becomes 1 exactly when the 0x60 correction is applied, V is signed overflow of the correction step and N, Z follow the new AL.
- R10: hc_o is the carry (add) or borrow (subtract) out of bit 3 of the adder used by every add, subtract, compare, increment and decrement form, byte or word; for all other codes hc_o equals hc_i.
- R11: Code NOP (0) and every code above DAS assert no write enable and return flags_o=flags_i and hc_o=hc_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Decoded operation code (package enumeration) |
| acc_i | input | 16 | Accumulator A; AL is bits 7:0 |
| tmp_i | input | 16 | Temporary register T; TL is bits 7:0 |
| opnd_i | input | 8 | Byte operand from register, immediate or memory |
| flags_i | input | 4 | Current N, Z, V, C |
| hc_i | input | 1 | Half carry captured from the previous add or subtract |
| res_o | output | 16 | Result word |
| wr_lo_o | output | 1 | Write res_o[7:0] to AL |
| wr_hi_o | output | 1 | Write res_o[15:8] to AH |
| wr_reg_o | output | 1 | Write res_o[7:0] to the general register operand |
| flags_o | output | 4 | Updated N, Z, V, C |
| hc_o | output | 1 | Half carry out for a later decimal adjust |

## Verification
The bench aims at operand order in the T-minus-A forms (a swapped subtractor gives the negated difference and the opposite borrow), at compares fed a set carry (a design that feeds C in returns a nonzero difference and clears Z), and at the flags that must survive untouched: C across register increment, V and C across word increment, V across rotates, and C across logic ops. Decimal adjust is driven at 0x9A, where both nibble corrections fire and the result wraps to zero with C set, and with a captured half carry, so a unit that ignores hc_i or tests the high digit alone misadjusts. Signed overflow at 0x7F/0x80 and 0x7FFF/0x8000 boundaries and unused codes are covered too.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   localparam int OP_W   = 5;
   localparam int FLAG_W = 4;
   localparam int FL_N   = 3;
   localparam int FL_Z   = 2;
   localparam int FL_V   = 1;
   localparam int FL_C   = 0;

   typedef enum logic [OP_W-1:0] {
      OP_NOP    = 5'd0,
      OP_ADDC_OP, OP_ADDC_T, OP_ADDCW,
      OP_SUBC_OP, OP_SUBC_T, OP_SUBCW,
      OP_CMP_OP,  OP_CMP_T,  OP_CMPW,
      OP_INC_R,   OP_DEC_R,  OP_INCW_A, OP_DECW_A,
      OP_AND_OP,  OP_OR_OP,  OP_XOR_OP, OP_AND_T, OP_XOR_T,
      OP_ANDW,    OP_ORW,    OP_XORW,
      OP_RORC,    OP_ROLC,
      OP_DAA,     OP_DAS
   } op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2
   } lg_e;

   typedef enum logic [3:0] {
      K_NONE, K_BADD, K_BCMP, K_BINC,
      K_WADD, K_WCMP, K_WINC,
      K_BLOG, K_WLOG, K_ROTR, K_ROTL, K_DEC
   } kind_e;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   input  logic         cin_i,
   input  logic         sub_i,
   output logic [W-1:0] sum_o,
   output logic         cy_o,
   output logic         ov_o,
   output logic         hc_o
);
   localparam int NIB = 4;

   logic [W-1:0] y_eff;
   logic         c_eff;
   logic [W:0]   full;
   logic [NIB:0] nib;

   generate
      if (W < NIB) begin : g_bad_w
         $error("acc_alu_addsub: W must be at least 4");
      end
   endgenerate

   // subtraction as x + ~y + ~borrow_in; carry out inverted gives borrow
   always_comb begin
      y_eff = sub_i ? ~y_i : y_i;
      c_eff = sub_i ? ~cin_i : cin_i;
      full  = {1'b0, x_i} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
      nib   = {1'b0, x_i[NIB-1:0]} + {1'b0, y_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
      sum_o = full[W-1:0];
      cy_o  = full[W] ^ sub_i;
      hc_o  = nib[NIB] ^ sub_i;
      ov_o  = (x_i[W-1] == y_eff[W-1]) && (sum_o[W-1] != x_i[W-1]);
   end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
   import acc_alu_pkg::*;
#(
   parameter int W = 16
) (
   input  lg_e          fn_i,
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] y_i,
   output logic [W-1:0] r_o
);
   always_comb begin
      unique case (fn_i)
         LG_AND:  r_o = x_i & y_i;
         LG_OR:   r_o = x_i | y_i;
         default: r_o = x_i ^ y_i;
      endcase
   end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
   parameter int W = 8
) (
   input  logic [W-1:0] val_i,
   input  logic         cy_i,
   input  logic         hc_i,
   input  logic         sub_i,
   output logic [W-1:0] res_o,
   output logic         cy_o,
   output logic         ov_o
);
   localparam int          NIB   = 4;
   localparam logic [W-1:0] SIX  = W'(6);
   localparam logic [W-1:0] HI_LIM = W'('h99);
   localparam logic [NIB-1:0] DIG_MAX = NIB'(9);

   logic         fix_lo;
   logic         fix_hi;
   logic [W-1:0] corr;

   generate
      if (W != 2 * NIB) begin : g_bad_w
         $error("acc_alu_decadj: only two BCD digits are supported");
      end
   endgenerate

   always_comb begin
      fix_lo = hc_i | (val_i[NIB-1:0] > DIG_MAX);
      fix_hi = cy_i | (val_i > HI_LIM);
      corr   = (fix_lo ? SIX : '0) | (fix_hi ? (SIX << NIB) : '0);
      res_o  = sub_i ? (val_i - corr) : (val_i + corr);
      cy_o   = fix_hi;
      // correction is always a positive value below half range
      ov_o   = sub_i ? (val_i[W-1] & ~res_o[W-1]) : (~val_i[W-1] & res_o[W-1]);
   end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter bit DECIMAL_EN = 1'b1
) (
   input  logic [OP_W-1:0]     op_i,
   input  logic [2*BYTE_W-1:0] acc_i,
   input  logic [2*BYTE_W-1:0] tmp_i,
   input  logic [BYTE_W-1:0]   opnd_i,
   input  logic [FLAG_W-1:0]   flags_i,
   input  logic                hc_i,
   output logic [2*BYTE_W-1:0] res_o,
   output logic                wr_lo_o,
   output logic                wr_hi_o,
   output logic                wr_reg_o,
   output logic [FLAG_W-1:0]   flags_o,
   output logic                hc_o
);
   localparam int WORD_W = 2 * BYTE_W;
   localparam int BMSB   = BYTE_W - 1;
   localparam int WMSB   = WORD_W - 1;

   generate
      if (BYTE_W < 4 || (BYTE_W % 4) != 0) begin : g_bad_byte
         $error("acc_alu: BYTE_W must be a nonzero multiple of 4");
      end
      if (DECIMAL_EN && BYTE_W != 8) begin : g_bad_dec
         $error("acc_alu: decimal adjust needs BYTE_W of 8");
      end
   endgenerate

   op_e   op;
   kind_e kind;

   logic [BYTE_W-1:0] acc_lo, acc_hi, tmp_lo;
   logic              c_in, v_in;

   logic [BYTE_W-1:0] b_x, b_y, b_sum;
   logic              b_cin, b_sub, b_cy, b_ov, b_hc;
   logic [WORD_W-1:0] w_x, w_y, w_sum;
   logic              w_cin, w_sub, w_cy, w_ov, w_hc;
   lg_e               l_fn;
   logic [WORD_W-1:0] l_x, l_y, l_r;
   logic [BYTE_W-1:0] rot_r, rot_l;
   logic [BYTE_W-1:0] d_r;
   logic              d_sub, d_c, d_v;

   assign op     = op_e'(op_i);
   assign acc_lo = acc_i[BMSB:0];
   assign acc_hi = acc_i[WMSB:BYTE_W];
   assign tmp_lo = tmp_i[BMSB:0];
   assign c_in   = flags_i[FL_C];
   assign v_in   = flags_i[FL_V];
   assign rot_r  = {c_in, acc_lo[BMSB:1]};
   assign rot_l  = {acc_lo[BMSB-1:0], c_in};

   // ---------------- operand steering ----------------
   always_comb begin
      b_x   = acc_lo;  b_y   = opnd_i; b_cin = c_in; b_sub = 1'b0;
      w_x   = acc_i;   w_y   = tmp_i;  w_cin = c_in; w_sub = 1'b0;
      l_fn  = LG_AND;
      l_x   = {{BYTE_W{1'b0}}, acc_lo};
      l_y   = {{BYTE_W{1'b0}}, opnd_i};
      d_sub = 1'b0;
      kind  = K_NONE;
      unique case (op)
         OP_ADDC_OP: kind = K_BADD;
         OP_ADDC_T:  begin b_y = tmp_lo; kind = K_BADD; end
         OP_ADDCW:   kind = K_WADD;
         OP_SUBC_OP: begin b_sub = 1'b1; kind = K_BADD; end
         OP_SUBC_T:  begin b_x = tmp_lo; b_y = acc_lo; b_sub = 1'b1; kind = K_BADD; end
         OP_SUBCW:   begin w_x = tmp_i; w_y = acc_i; w_sub = 1'b1; kind = K_WADD; end
         OP_CMP_OP:  begin b_sub = 1'b1; b_cin = 1'b0; kind = K_BCMP; end
         OP_CMP_T:   begin
            b_x = tmp_lo; b_y = acc_lo; b_sub = 1'b1; b_cin = 1'b0; kind = K_BCMP;
         end
         OP_CMPW:    begin
            w_x = tmp_i; w_y = acc_i; w_sub = 1'b1; w_cin = 1'b0; kind = K_WCMP;
         end
         OP_INC_R:   begin b_x = opnd_i; b_y = '0; b_cin = 1'b1; kind = K_BINC; end
         OP_DEC_R:   begin
            b_x = opnd_i; b_y = '0; b_cin = 1'b1; b_sub = 1'b1; kind = K_BINC;
         end
         OP_INCW_A:  begin w_y = '0; w_cin = 1'b1; kind = K_WINC; end
         OP_DECW_A:  begin w_y = '0; w_cin = 1'b1; w_sub = 1'b1; kind = K_WINC; end
         OP_AND_OP:  begin l_fn = LG_AND; kind = K_BLOG; end
         OP_OR_OP:   begin l_fn = LG_OR;  kind = K_BLOG; end
         OP_XOR_OP:  begin l_fn = LG_XOR; kind = K_BLOG; end
         OP_AND_T:   begin l_fn = LG_AND; l_y = {{BYTE_W{1'b0}}, tmp_lo}; kind = K_BLOG; end
         OP_XOR_T:   begin l_fn = LG_XOR; l_y = {{BYTE_W{1'b0}}, tmp_lo}; kind = K_BLOG; end
         OP_ANDW:    begin l_fn = LG_AND; l_x = acc_i; l_y = tmp_i; kind = K_WLOG; end
         OP_ORW:     begin l_fn = LG_OR;  l_x = acc_i; l_y = tmp_i; kind = K_WLOG; end
         OP_XORW:    begin l_fn = LG_XOR; l_x = acc_i; l_y = tmp_i; kind = K_WLOG; end
         OP_RORC:    kind = K_ROTR;
         OP_ROLC:    kind = K_ROTL;
         OP_DAA:     kind = DECIMAL_EN ? K_DEC : K_NONE;
         OP_DAS:     begin d_sub = 1'b1; kind = DECIMAL_EN ? K_DEC : K_NONE; end
         default:    kind = K_NONE;
      endcase
   end

   // ---------------- shared datapath ----------------
   acc_alu_addsub #(.W(BYTE_W)) u_badd (
      .x_i(b_x), .y_i(b_y), .cin_i(b_cin), .sub_i(b_sub),
      .sum_o(b_sum), .cy_o(b_cy), .ov_o(b_ov), .hc_o(b_hc)
   );

   acc_alu_addsub #(.W(WORD_W)) u_wadd (
      .x_i(w_x), .y_i(w_y), .cin_i(w_cin), .sub_i(w_sub),
      .sum_o(w_sum), .cy_o(w_cy), .ov_o(w_ov), .hc_o(w_hc)
   );

   acc_alu_logic #(.W(WORD_W)) u_logic (
      .fn_i(l_fn), .x_i(l_x), .y_i(l_y), .r_o(l_r)
   );

   generate
      if (DECIMAL_EN) begin : g_dec
         acc_alu_decadj #(.W(BYTE_W)) u_dec (
            .val_i(acc_lo), .cy_i(c_in), .hc_i(hc_i), .sub_i(d_sub),
            .res_o(d_r), .cy_o(d_c), .ov_o(d_v)
         );
      end else begin : g_nodec
         assign d_r = '0;
         assign d_c = 1'b0;
         assign d_v = 1'b0;
      end
   endgenerate

   // ---------------- result, enables and flags ----------------
   always_comb begin
      res_o    = acc_i;
      wr_lo_o  = 1'b0;
      wr_hi_o  = 1'b0;
      wr_reg_o = 1'b0;
      flags_o  = flags_i;
      hc_o     = hc_i;
      unique case (kind)
         K_BADD: begin
            res_o   = {acc_hi, b_sum};
            wr_lo_o = 1'b1;
            flags_o = {b_sum[BMSB], b_sum == '0, b_ov, b_cy};
            hc_o    = b_hc;
         end
         K_BCMP: begin
            flags_o = {b_sum[BMSB], b_sum == '0, b_ov, b_cy};
            hc_o    = b_hc;
         end
         K_BINC: begin
            res_o    = {{BYTE_W{1'b0}}, b_sum};
            wr_reg_o = 1'b1;
            flags_o  = {b_sum[BMSB], b_sum == '0, b_ov, c_in};
            hc_o     = b_hc;
         end
         K_WADD: begin
            res_o   = w_sum;
            wr_lo_o = 1'b1;
            wr_hi_o = 1'b1;
            flags_o = {w_sum[WMSB], w_sum == '0, w_ov, w_cy};
            hc_o    = w_hc;
         end
         K_WCMP: begin
            flags_o = {w_sum[WMSB], w_sum == '0, w_ov, w_cy};
            hc_o    = w_hc;
         end
         K_WINC: begin
            res_o   = w_sum;
            wr_lo_o = 1'b1;
            wr_hi_o = 1'b1;
            flags_o = {w_sum[WMSB], w_sum == '0, v_in, c_in};
            hc_o    = w_hc;
         end
         K_BLOG: begin
            res_o   = {acc_hi, l_r[BMSB:0]};
            wr_lo_o = 1'b1;
            flags_o = {l_r[BMSB], l_r[BMSB:0] == '0, 1'b0, c_in};
         end
         K_WLOG: begin
            res_o   = l_r;
            wr_lo_o = 1'b1;
            wr_hi_o = 1'b1;
            flags_o = {l_r[WMSB], l_r == '0, 1'b0, c_in};
         end
         K_ROTR: begin
            res_o   = {acc_hi, rot_r};
            wr_lo_o = 1'b1;
            flags_o = {rot_r[BMSB], rot_r == '0, v_in, acc_lo[0]};
         end
         K_ROTL: begin
            res_o   = {acc_hi, rot_l};
            wr_lo_o = 1'b1;
            flags_o = {rot_l[BMSB], rot_l == '0, v_in, acc_lo[BMSB]};
         end
         K_DEC: begin
            res_o   = {acc_hi, d_r};
            wr_lo_o = 1'b1;
            flags_o = {d_r[BMSB], d_r == '0, d_v, d_c};
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
   import acc_alu_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input logic [OP_W-1:0]     op_i,
   input logic [2*BYTE_W-1:0] acc_i,
   input logic [FLAG_W-1:0]   flags_i,
   input logic                hc_i,
   input logic [2*BYTE_W-1:0] res_o,
   input logic                wr_lo_o,
   input logic                wr_hi_o,
   input logic                wr_reg_o,
   input logic [FLAG_W-1:0]   flags_o,
   input logic                hc_o
);
   always_comb begin
      // word writes always carry the low byte with them
      assert_hi_with_lo_R2: assert (!wr_hi_o || wr_lo_o);
      // a word write reports Z over the full 16-bit result
      if (wr_hi_o) begin
         assert_word_zero_R2: assert (flags_o[FL_Z] == (res_o == '0));
      end
      if (op_i == OP_CMP_OP || op_i == OP_CMP_T || op_i == OP_CMPW) begin
         assert_cmp_nowrite_R4: assert (!wr_lo_o && !wr_hi_o && !wr_reg_o);
      end
      if (op_i == OP_INC_R || op_i == OP_DEC_R) begin
         assert_reg_keepc_R5: assert (flags_o[FL_C] == flags_i[FL_C] && wr_reg_o && !wr_lo_o);
      end
      if (op_i == OP_INCW_A || op_i == OP_DECW_A) begin
         assert_word_step_keepvc_R6: assert (flags_o[FL_V:FL_C] == flags_i[FL_V:FL_C]);
      end
      if (op_i >= OP_AND_OP && op_i <= OP_XORW) begin
         assert_logic_vclr_R7: assert (!flags_o[FL_V] && flags_o[FL_C] == flags_i[FL_C]);
      end
      if (op_i == OP_RORC || op_i == OP_ROLC) begin
         assert_rot_keepv_R8: assert (flags_o[FL_V] == flags_i[FL_V] && res_o[15:8] == acc_i[15:8]);
      end
      if (op_i == OP_NOP || op_i > OP_DAS) begin
         assert_idle_quiet_R11: assert (!wr_lo_o && !wr_hi_o && !wr_reg_o
                                        && flags_o == flags_i && hc_o == hc_i);
      end
   end
endmodule

bind acc_alu acc_alu_chk #(.BYTE_W(BYTE_W)) u_chk (
   .op_i(op_i), .acc_i(acc_i), .flags_i(flags_i), .hc_i(hc_i),
   .res_o(res_o), .wr_lo_o(wr_lo_o), .wr_hi_o(wr_hi_o), .wr_reg_o(wr_reg_o),
   .flags_o(flags_o), .hc_o(hc_o)
);

// File: tb/acc_alu_test.sv
`timescale 1ns/1ps
module acc_alu_test;
   import acc_alu_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [4:0]  op_i    = 5'd0;
   logic [15:0] acc_i   = '0;
   logic [15:0] tmp_i   = '0;
   logic [7:0]  opnd_i  = '0;
   logic [3:0]  flags_i = '0;
   logic        hc_i    = 1'b0;
   logic [15:0] res_o;
   logic        wr_lo_o, wr_hi_o, wr_reg_o, hc_o;
   logic [3:0]  flags_o;

   acc_alu uut (
      .op_i(op_i), .acc_i(acc_i), .tmp_i(tmp_i), .opnd_i(opnd_i),
      .flags_i(flags_i), .hc_i(hc_i), .res_o(res_o),
      .wr_lo_o(wr_lo_o), .wr_hi_o(wr_hi_o), .wr_reg_o(wr_reg_o),
      .flags_o(flags_o), .hc_o(hc_o)
   );

   typedef struct {
      logic [15:0] res;
      logic        wl, wh, wr;
      logic [3:0]  fl;
      logic        hc;
      string       req;
   } item_t;

   typedef struct { int r; bit c, v, h; } ar_t;

   item_t q[$];
   int    total = 0;
   int    bad   = 0;
   bit    done  = 1'b0;

   function automatic ar_t arith(int x, int y, int cin, bit sub, int w);
      ar_t a;
      int mask = (1 << w) - 1;
      int top  = 1 << (w - 1);
      int s, hs;
      s   = sub ? (x - y - cin) : (x + y + cin);
      a.r = s & mask;
      a.c = sub ? (s < 0) : (s > mask);
      a.v = sub ? (((x ^ y) & (x ^ a.r) & top) != 0)
                : (((~(x ^ y)) & (x ^ a.r) & top) != 0);
      hs  = sub ? ((x & 15) - (y & 15) - cin) : ((x & 15) + (y & 15) + cin);
      a.h = sub ? (hs < 0) : (hs > 15);
      return a;
   endfunction

   function automatic item_t model(logic [4:0] op, logic [15:0] a, logic [15:0] t,
                                   logic [7:0] o, logic [3:0] f, logic hc);
      item_t e;
      ar_t   r;
      int    al = a[7:0], tl = t[7:0], c = f[0], x;
      bit    fl_lo, fl_hi;
      e.res = a; e.wl = 0; e.wh = 0; e.wr = 0; e.fl = f; e.hc = hc; e.req = "";
      case (op)
         OP_ADDC_OP, OP_ADDC_T, OP_SUBC_OP, OP_SUBC_T, OP_CMP_OP, OP_CMP_T: begin
            if (op == OP_ADDC_OP)      r = arith(al, o, c, 0, 8);
            else if (op == OP_ADDC_T)  r = arith(al, tl, c, 0, 8);
            else if (op == OP_SUBC_OP) r = arith(al, o, c, 1, 8);
            else if (op == OP_SUBC_T)  r = arith(tl, al, c, 1, 8);
            else if (op == OP_CMP_OP)  r = arith(al, o, 0, 1, 8);
            else                       r = arith(tl, al, 0, 1, 8);
            e.fl = {r.r[7], r.r == 0, r.v, r.c};
            e.hc = r.h;
            if (op != OP_CMP_OP && op != OP_CMP_T) begin
               e.res = {a[15:8], r.r[7:0]}; e.wl = 1;
            end
         end
         OP_ADDCW, OP_SUBCW, OP_CMPW: begin
            if (op == OP_ADDCW)      r = arith(a, t, c, 0, 16);
            else if (op == OP_SUBCW) r = arith(t, a, c, 1, 16);
            else                     r = arith(t, a, 0, 1, 16);
            e.fl = {r.r[15], r.r == 0, r.v, r.c};
            e.hc = r.h;
            if (op != OP_CMPW) begin
               e.res = r.r[15:0]; e.wl = 1; e.wh = 1;
            end
         end
         OP_INC_R, OP_DEC_R: begin
            r = arith(o, 0, 1, op == OP_DEC_R, 8);
            e.res = {8'h00, r.r[7:0]}; e.wr = 1;
            e.fl = {r.r[7], r.r == 0, r.v, f[0]};
            e.hc = r.h;
         end
         OP_INCW_A, OP_DECW_A: begin
            r = arith(a, 0, 1, op == OP_DECW_A, 16);
            e.res = r.r[15:0]; e.wl = 1; e.wh = 1;
            e.fl = {r.r[15], r.r == 0, f[1], f[0]};
            e.hc = r.h;
         end
         OP_AND_OP, OP_OR_OP, OP_XOR_OP, OP_AND_T, OP_XOR_T: begin
            case (op)
               OP_AND_OP: x = al & o;
               OP_OR_OP:  x = al | o;
               OP_XOR_OP: x = al ^ o;
               OP_AND_T:  x = al & tl;
               default:   x = al ^ tl;
            endcase
            e.res = {a[15:8], x[7:0]}; e.wl = 1;
            e.fl = {x[7], x == 0, 1'b0, f[0]};
         end
         OP_ANDW, OP_ORW, OP_XORW: begin
            x = (op == OP_ANDW) ? (a & t) : (op == OP_ORW) ? (a | t) : (a ^ t);
            e.res = x[15:0]; e.wl = 1; e.wh = 1;
            e.fl = {x[15], x == 0, 1'b0, f[0]};
         end
         OP_RORC, OP_ROLC: begin
            if (op == OP_RORC) begin x = (c << 7) | (al >> 1); e.fl[0] = al[0]; end
            else begin x = ((al << 1) & 255) | c; e.fl[0] = al[7]; end
            e.res = {a[15:8], x[7:0]}; e.wl = 1;
            e.fl[3] = x[7]; e.fl[2] = (x == 0);
         end
         OP_DAA, OP_DAS: begin
            fl_lo = hc || ((al & 15) > 9);
            fl_hi = (c != 0) || (al > 'h99);
            if (op == OP_DAA) begin
               x = (al + (fl_lo ? 6 : 0) + (fl_hi ? 'h60 : 0)) & 255;
               e.fl[1] = (al < 128) && (x >= 128);
            end else begin
               x = (al - (fl_lo ? 6 : 0) - (fl_hi ? 'h60 : 0)) & 255;
               e.fl[1] = (al >= 128) && (x < 128);
            end
            e.res = {a[15:8], x[7:0]}; e.wl = 1;
            e.fl[3] = x[7]; e.fl[2] = (x == 0); e.fl[0] = fl_hi;
         end
         default: ;
      endcase
      return e;
   endfunction

   function automatic string req_of(logic [4:0] op);
      case (op)
         OP_ADDC_OP, OP_ADDC_T:            return "R1";
         OP_ADDCW:                         return "R2";
         OP_SUBC_OP, OP_SUBC_T, OP_SUBCW:  return "R3";
         OP_CMP_OP, OP_CMP_T, OP_CMPW:     return "R4";
         OP_INC_R, OP_DEC_R:               return "R5";
         OP_INCW_A, OP_DECW_A:             return "R6";
         OP_RORC, OP_ROLC:                 return "R8";
         OP_DAA, OP_DAS:                   return "R9";
         default: begin
            if (op >= OP_AND_OP && op <= OP_XORW) return "R7";
            return "R11";
         end
      endcase
   endfunction

   // driver: applies stimulus at the falling edge and queues the expectation
   task automatic drive(logic [4:0] op, logic [15:0] a, logic [15:0] t, logic [7:0] o,
                        logic [3:0] f, logic h, string req);
      item_t e;
      @(negedge clk);
      op_i = op; acc_i = a; tmp_i = t; opnd_i = o; flags_i = f; hc_i = h;
      e = model(op, a, t, o, f, h);
      e.req = (req == "") ? req_of(op) : req;
      q.push_back(e);
   endtask

   // monitor: compares at the rising edge, half a period after the inputs moved
   always @(posedge clk) begin
      item_t e;
      logic [15:0] act_res;
      logic [15:0] exp_res;
      if (rst_n && q.size() > 0) begin
         e = q.pop_front();
         act_res = (e.wl || e.wh || e.wr) ? res_o : 16'h0;
         exp_res = (e.wl || e.wh || e.wr) ? e.res : 16'h0;
         total++;
         if ({act_res, wr_lo_o, wr_hi_o, wr_reg_o, flags_o, hc_o} !==
             {exp_res, e.wl, e.wh, e.wr, e.fl, e.hc}) begin
            bad++;
            $display("FAIL %s op=%0d act res=%h we=%b%b%b fl=%b hc=%b exp res=%h we=%b%b%b fl=%b hc=%b",
                     e.req, op_i, act_res, wr_lo_o, wr_hi_o, wr_reg_o, flags_o, hc_o,
                     exp_res, e.wl, e.wh, e.wr, e.fl, e.hc);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R11 watchdog expired act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [4:0] rop;
      // reset state: idle code with a flag pattern must pass flags through, no writes
      flags_i = 4'b0101; hc_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if ({wr_lo_o, wr_hi_o, wr_reg_o, flags_o, hc_o} !== {3'b000, 4'b0101, 1'b1}) begin
         bad++;
         $display("FAIL R11 reset idle act=%b%b%b %b %b exp=000 0101 1",
                  wr_lo_o, wr_hi_o, wr_reg_o, flags_o, hc_o);
      end
      rst_n = 1'b1;

      // R1 byte add
      drive(OP_ADDC_OP, 16'h127F, 16'h0000, 8'h01, 4'b0000, 0, "R1");
      drive(OP_ADDC_T,  16'h00FF, 16'h0001, 8'h55, 4'b0001, 0, "R1");
      // R2 word add
      drive(OP_ADDCW,   16'hFFFF, 16'h0000, 8'h00, 4'b0001, 0, "R2");
      drive(OP_ADDCW,   16'h7FFF, 16'h0001, 8'h00, 4'b0000, 0, "R2");
      // R3 subtract, operand order for T forms
      drive(OP_SUBC_OP, 16'hAB00, 16'h0000, 8'h01, 4'b0000, 0, "R3");
      drive(OP_SUBC_T,  16'h0003, 16'h0005, 8'h00, 4'b0000, 0, "R3");
      drive(OP_SUBCW,   16'h0001, 16'h8000, 8'h00, 4'b0000, 0, "R3");
      drive(OP_SUBCW,   16'h0002, 16'h0001, 8'h00, 4'b0001, 0, "R3");
      // R4 compare ignores carry in and writes nothing
      drive(OP_CMP_OP,  16'h0042, 16'h0000, 8'h42, 4'b0001, 0, "R4");
      drive(OP_CMP_T,   16'h0020, 16'h0010, 8'h00, 4'b0000, 0, "R4");
      drive(OP_CMPW,    16'h1234, 16'h1234, 8'h00, 4'b0001, 0, "R4");
      // R5 register inc/dec keep C
      drive(OP_INC_R,   16'h5555, 16'h0000, 8'h7F, 4'b0001, 0, "R5");
      drive(OP_DEC_R,   16'h5555, 16'h0000, 8'h00, 4'b0000, 0, "R5");
      drive(OP_DEC_R,   16'h5555, 16'h0000, 8'h80, 4'b0001, 0, "R5");
      // R6 word inc/dec keep V and C
      drive(OP_INCW_A,  16'hFFFF, 16'h0000, 8'h00, 4'b0010, 0, "R6");
      drive(OP_DECW_A,  16'h0000, 16'h0000, 8'h00, 4'b0001, 0, "R6");
      // R7 logic
      drive(OP_ANDW,    16'hF0F0, 16'h0F0F, 8'h00, 4'b0011, 0, "R7");
      drive(OP_ORW,     16'h8000, 16'h0001, 8'h00, 4'b0010, 0, "R7");
      drive(OP_XORW,    16'hFFFF, 16'h00FF, 8'h00, 4'b0000, 0, "R7");
      drive(OP_AND_OP,  16'h12F0, 16'h0000, 8'h0F, 4'b0011, 0, "R7");
      drive(OP_OR_OP,   16'h1201, 16'h0000, 8'h80, 4'b0010, 0, "R7");
      drive(OP_XOR_OP,  16'h34AA, 16'h0000, 8'hAA, 4'b0001, 0, "R7");
      drive(OP_AND_T,   16'h00C3, 16'h0081, 8'h00, 4'b0010, 0, "R7");
      drive(OP_XOR_T,   16'h00C3, 16'h0081, 8'h00, 4'b0000, 0, "R7");
      // R8 rotate through carry, V kept
      drive(OP_RORC,    16'h7701, 16'h0000, 8'h00, 4'b0011, 0, "R8");
      drive(OP_ROLC,    16'h7780, 16'h0000, 8'h00, 4'b0010, 0, "R8");
      // R9 decimal adjust corners
      drive(OP_DAA,     16'h009A, 16'h0000, 8'h00, 4'b0000, 0, "R9");
      drive(OP_DAA,     16'h0015, 16'h0000, 8'h00, 4'b0000, 1, "R9");
      drive(OP_DAA,     16'h0042, 16'h0000, 8'h00, 4'b0001, 0, "R9");
      drive(OP_DAS,     16'h000F, 16'h0000, 8'h00, 4'b0000, 1, "R9");
      drive(OP_DAS,     16'h00A0, 16'h0000, 8'h00, 4'b0001, 0, "R9");
      // R10 half carry out of bit 3, pass-through elsewhere
      drive(OP_ADDC_OP, 16'h000F, 16'h0000, 8'h01, 4'b0000, 0, "R10");
      drive(OP_SUBC_OP, 16'h0010, 16'h0000, 8'h01, 4'b0000, 0, "R10");
      drive(OP_INCW_A,  16'h000F, 16'h0000, 8'h00, 4'b0000, 0, "R10");
      drive(OP_XORW,    16'h000F, 16'h0000, 8'h00, 4'b0000, 1, "R10");
      // R11 idle and unused codes
      drive(OP_NOP,     16'h1234, 16'h5678, 8'h9A, 4'b1010, 1, "R11");
      drive(5'd31,      16'h1234, 16'h5678, 8'h9A, 4'b0101, 0, "R11");
      drive(5'd26,      16'h0000, 16'h0000, 8'h00, 4'b1111, 1, "R11");

      // mixed patterns over every code
      for (int i = 0; i < 400; i++) begin
         rop = 5'($urandom_range(0, 31));
         drive(rop, 16'($urandom), 16'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), "");
      end

      @(negedge clk);
      op_i = 5'd0;
      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule